// File: doc/BRIEF.md
# Codec Startup Sequencer

This block sits on the controller side of a serial audio codec and takes it from power-up to data mode without software help. It first holds the codec's reset pin low for a fixed number of cycles. It then releases reset while the data/control select stays low. From that point it runs the serial clock and frame sync for a settling window, so that the codec sees a stable clock and an unchanging control word before the handshake starts.

The handshake has two polled stages. In the first stage the sequencer repeats a control word with the handshake bit cleared. It keeps doing so until a fully received echo frame shows that bit cleared. In the second stage it repeats the desired control word with the handshake bit set, until the echo shows the bit set. After the final echo frame it keeps the serial clock running for a minimum number of extra clock periods. It then stops the clock, raises the select and pulses a done flag. If either stage does not get its echo within a set number of frames, the sequencer stops in an error state.

Top module: `codec_bringup_seq`

## Requirements
- R1: While `rst_n` is low, and for RST_CYC clock cycles after it rises, `cdc_rst_n`, `cdc_sclk`, `cdc_fsync`, `cdc_dc`, `done` and `err` are all low.
- R2: After that window, `cdc_rst_n` is high and `cdc_dc` stays low. The serial clock runs with a period of two `clk` cycles and starts low. Frames are W serial-clock periods long. `cdc_fsync` is high for the whole first bit period of each frame. Word bit W-1 is sent first. `cdc_sdo` changes when the serial clock falls, and `cdc_sdi` is sampled on the `clk` edge where the serial clock rises.
- R3: After SETTLE_FRM frames, every outgoing frame is the latched control word with bit HS_BIT forced to 0. This repeats until a completed received frame has bit HS_BIT equal to 0. In received frames, too, the first bit received is bit W-1.
- R4: No outgoing frame carries bit HS_BIT = 1 before a received frame with that bit at 0 has been completed during the first stage.
- R5: After the zero echo, every outgoing frame is the latched control word with bit HS_BIT forced to 1. This repeats until a completed received frame shows bit HS_BIT = 1.
- R6: Received frames that complete during the settling window are not evaluated. A zero echo received there does not shorten the window.
- R7: The frame in which the echo 1 arrives is counted as the final echo frame. From the start of that frame, the serial clock gives TRAIL_CLK rising edges in total. It then stays low, and `cdc_dc` rises on the same edge as the last fall of the serial clock.
- R8: `done` is high for exactly one cycle, on the edge where `cdc_dc` rises. `cdc_dc` then stays high until `rst_n` is asserted.
- R9: If POLL_MAX frames complete in either stage without the expected echo, `err` rises and stays high. The serial clock and frame sync stop low, and `cdc_dc` never rises.
- R10: `ctl_word` is latched on the edge where the codec reset is released. Later changes to the input have no effect on the transmitted frames.
- R11: Asserting `rst_n` at any point in the sequence returns every output to the R1 state, and the sequence restarts from the beginning.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_word | input | W | Desired control word, latched at codec reset release |
| cdc_sdi | input | 1 | Serial data from codec |
| cdc_rst_n | output | 1 | Codec reset, active low |
| cdc_dc | output | 1 | Data/control select, high means data mode |
| cdc_sclk | output | 1 | Serial clock to codec |
| cdc_fsync | output | 1 | Frame sync, high during the first bit of a frame |
| cdc_sdo | output | 1 | Serial data to codec |
| done | output | 1 | One-cycle pulse when data mode is entered |
| err | output | 1 | Sticky handshake timeout flag |

## Verification
An emulated codec echoes each received frame with a configurable lag before each echo value changes. This gives several patterns: immediate echoes, which show that settling-window frames are ignored; short lags in both stages; a lag of exactly POLL_MAX-2 frames in the second stage, which is the last frame that still succeeds; and a lag one frame longer, which must time out. Very long lags in the first stage and in the second stage show that the timeout applies to each stage separately. Every received frame is compared with the word latched at reset release while the input word is changed, and every frame is checked for a set handshake bit before the zero echo. One run asserts reset in the middle of the second stage and then repeats the sequence from the start.

// File: rtl/codec_bringup_seq.sv
module codec_bringup_seq #(
  parameter int W          = 64,
  parameter int HS_BIT     = 58,
  parameter int RST_CYC    = 1000,
  parameter int SETTLE_FRM = 4,
  parameter int POLL_MAX   = 16,
  parameter int TRAIL_CLK  = 65
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ctl_word,
  input  logic         cdc_sdi,
  output logic         cdc_rst_n,
  output logic         cdc_dc,
  output logic         cdc_sclk,
  output logic         cdc_fsync,
  output logic         cdc_sdo,
  output logic         done,
  output logic         err
);
  localparam int BW    = (W > 1) ? $clog2(W) : 1;
  localparam int RW    = HS_BIT + 1;
  localparam int EXTRA = (TRAIL_CLK > W) ? TRAIL_CLK - W : 1;
  localparam logic [W-1:0] HS_MASK = {{(W-1){1'b0}}, 1'b1} << HS_BIT;

  typedef enum logic [2:0] {S_RST, S_CLK, S_LO, S_HI, S_TRL, S_DONE, S_ERR} st_t;

  st_t           st;
  logic [31:0]   cnt;
  logic          ph;
  logic [BW-1:0] bitc;
  logic [RW-1:0] rxsr;
  logic [W-1:0]  ctl_lat;

  wire run     = (st == S_CLK) || (st == S_LO) || (st == S_HI) || (st == S_TRL);
  wire tick_r  = run & ~ph;
  wire tick_f  = run & ph;
  wire frm_end = tick_f && (bitc == BW'(W-1));
  wire echo    = rxsr[HS_BIT];
  wire hs_val  = (st == S_HI) || (st == S_TRL);
  wire [W-1:0]  tx_word = hs_val ? (ctl_lat | HS_MASK) : (ctl_lat & ~HS_MASK);
  wire [BW-1:0] wsel    = BW'(W-1) - bitc;

  assign cdc_rst_n = (st != S_RST);
  assign cdc_sclk  = run & ph;
  assign cdc_fsync = run && (bitc == '0);
  assign cdc_sdo   = run & tx_word[wsel];
  assign err       = (st == S_ERR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_RST;
      cnt     <= '0;
      ph      <= 1'b0;
      bitc    <= '0;
      rxsr    <= '0;
      ctl_lat <= '0;
      cdc_dc  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      ph   <= run ? ~ph : 1'b0;
      if (tick_r) rxsr <= RW'({rxsr, cdc_sdi});
      if (tick_f) bitc <= frm_end ? '0 : bitc + 1'b1;
      case (st)
        S_RST:
          if (cnt == RST_CYC - 1) begin
            st      <= S_CLK;
            cnt     <= '0;
            ctl_lat <= ctl_word;
          end else cnt <= cnt + 1;
        S_CLK:
          if (frm_end) begin
            if (cnt == SETTLE_FRM - 1) begin
              st  <= S_LO;
              cnt <= '0;
            end else cnt <= cnt + 1;
          end
        S_LO:
          if (frm_end) begin
            if (!echo) begin
              st  <= S_HI;
              cnt <= '0;
            end else if (cnt == POLL_MAX - 1) st <= S_ERR;
            else cnt <= cnt + 1;
          end
        S_HI:
          if (frm_end) begin
            if (echo) begin
              st  <= S_TRL;
              cnt <= '0;
            end else if (cnt == POLL_MAX - 1) st <= S_ERR;
            else cnt <= cnt + 1;
          end
        S_TRL:
          if (tick_f) begin
            if (cnt == EXTRA - 1) begin
              st     <= S_DONE;
              cdc_dc <= 1'b1;
              done   <= 1'b1;
            end else cnt <= cnt + 1;
          end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/codec_bringup_chk.sv
module codec_bringup_chk (
  input logic clk,
  input logic rst_n,
  input logic cdc_rst_n,
  input logic cdc_dc,
  input logic cdc_sclk,
  input logic done,
  input logic err
);
  p_quiet_in_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cdc_rst_n |-> (!cdc_sclk && !cdc_dc && !err));

  p_dc_after_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cdc_dc |-> cdc_rst_n);

  p_clock_stops_at_dc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cdc_dc |-> !cdc_sclk);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_with_dc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cdc_dc) |-> done);

  p_dc_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cdc_dc |=> cdc_dc);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (err && !cdc_dc && !cdc_sclk));
endmodule

bind codec_bringup_seq codec_bringup_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cdc_rst_n(cdc_rst_n), .cdc_dc(cdc_dc),
  .cdc_sclk(cdc_sclk), .done(done), .err(err)
);

// File: tb/sim_codec_bringup_seq.sv
module sim_codec_bringup_seq;
  localparam int CLK_PERIOD = 10;
  localparam int W     = 64;
  localparam int HS    = 58;
  localparam int RSTC  = 20;
  localparam int SETF  = 2;
  localparam int PMAX  = 6;
  localparam int TRAIL = 65;
  localparam int EXTRA = TRAIL - W;

  logic clk = 1'b0, rst_n = 1'b0, sdi = 1'b0;
  logic [W-1:0] ctl_word = '0;
  logic cdc_rst_n, cdc_dc, cdc_sclk, cdc_fsync, cdc_sdo, done, err;

  always #(CLK_PERIOD/2) clk = ~clk;

  codec_bringup_seq #(.W(W), .HS_BIT(HS), .RST_CYC(RSTC), .SETTLE_FRM(SETF),
                      .POLL_MAX(PMAX), .TRAIL_CLK(TRAIL)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_word(ctl_word), .cdc_sdi(sdi),
    .cdc_rst_n(cdc_rst_n), .cdc_dc(cdc_dc), .cdc_sclk(cdc_sclk),
    .cdc_fsync(cdc_fsync), .cdc_sdo(cdc_sdo), .done(done), .err(err));

  int nchk = 0, nerr = 0;
  int mph = 0, mcnt = 0, mt = 0, mdone = 0;
  logic [W-1:0] exp_ctl = '0;
  int lag0 = 0, lag1 = 0, eho = 1, pend = 0, have_last = 0, cur_echo = 1, sent0 = 0;
  logic [W-1:0] rxw = '0, lastw = '0, echow = '0, ew;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  // reference model: integer stage, counter and running-time count
  always @(posedge clk) begin
    if (!rst_n) begin
      mph = 0; mcnt = 0; mt = 0; mdone = 0;
    end else begin
      mdone = 0;
      if (mph == 0) begin
        if (mcnt == RSTC - 1) begin mph = 1; mcnt = 0; mt = 0; exp_ctl = ctl_word; end
        else mcnt++;
      end else if (mph >= 1 && mph <= 4) begin
        if (mph == 1 && (mt % (2*W)) == 2*W-1) begin
          if (mcnt == SETF - 1) begin mph = 2; mcnt = 0; end else mcnt++;
        end else if (mph == 2 && (mt % (2*W)) == 2*W-1) begin
          if (cur_echo == 0) begin mph = 3; mcnt = 0; end
          else if (mcnt == PMAX - 1) mph = 6;
          else mcnt++;
        end else if (mph == 3 && (mt % (2*W)) == 2*W-1) begin
          if (cur_echo == 1) begin mph = 4; mcnt = 0; end
          else if (mcnt == PMAX - 1) mph = 6;
          else mcnt++;
        end else if (mph == 4 && (mt % 2) == 1) begin
          if (mcnt == EXTRA - 1) begin mph = 5; mdone = 1; end else mcnt++;
        end
        mt++;
      end
    end
  end

  // emulated codec and per-clock comparison
  always @(negedge clk) begin
    int k;
    int lh;
    bit run;
    if (!rst_n) begin
      mph = 0; mcnt = 0; mt = 0; mdone = 0;
      eho = 1; pend = 0; have_last = 0; cur_echo = 1; sent0 = 0; sdi = 1'b0;
    end else if (mph >= 1 && mph <= 4 && (mt % 2) == 0) begin
      k = (mt / 2) % W;
      if (k == 0) begin
        if (have_last != 0) begin
          lh = int'(lastw[HS]);
          if (lh != eho) begin
            pend++;
            if (pend > ((lh != 0) ? lag1 : lag0)) begin eho = lh; pend = 0; end
          end else pend = 0;
          echow = lastw;
        end else echow = '0;
        echow[HS] = eho[0];
        cur_echo = eho;
      end
      sdi = echow[W-1-k];
      rxw[W-1-k] = cdc_sdo;
      if (k == W-1) begin
        ew = exp_ctl;
        ew[HS] = (mph == 3);
        if (mph == 3) chk("R5 R10 frame word", rxw, ew);
        else          chk("R3 R10 frame word", rxw, ew);
        chk("R4 handshake bit before zero echo", 64'(rxw[HS] && sent0 == 0), 64'(0));
        lastw = rxw;
        have_last = 1;
        if (mph == 2 && cur_echo == 0) sent0 = 1;
      end
    end
    run = (mph >= 1 && mph <= 4);
    chk("R1 R2 R11 cdc_rst_n", 64'(cdc_rst_n), 64'(mph != 0));
    chk("R2 R7 cdc_sclk", 64'(cdc_sclk), 64'(run && (mt % 2) == 1));
    chk("R2 cdc_fsync", 64'(cdc_fsync), 64'(run && ((mt / 2) % W) == 0));
    chk("R6 R7 cdc_dc", 64'(cdc_dc), 64'(mph == 5));
    chk("R8 done", 64'(done), 64'(mdone));
    chk("R9 err", 64'(err), 64'(mph == 6));
  end

  task automatic run_case(input int l0, input int l1, input logic [W-1:0] c,
                          input int want, input bit midrst);
    int guard;
    @(posedge clk); #1;
    rst_n = 1'b0; lag0 = l0; lag1 = l1; ctl_word = c;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    guard = 0;
    while (mph < 5 && guard < 20000) begin
      @(posedge clk); #1;
      guard++;
      if (mph == 2) ctl_word = ~c;  // R10: late change must not reach frames
      if (midrst && mph == 3) begin
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11 reset mid run cdc_rst_n", 64'(cdc_rst_n), 64'(0));
        chk("R11 reset mid run sclk", 64'(cdc_sclk), 64'(0));
        @(posedge clk); #1 rst_n = 1'b1;
        midrst = 1'b0;
      end
    end
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk("R9 final err", 64'(err), 64'(want == 6));
    chk("R7 final dc", 64'(cdc_dc), 64'(want == 5));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    run_case(1, 1, 64'h0123_4567_89AB_CDEF, 5, 1'b0);
    run_case(0, 0, {W{1'b1}}, 5, 1'b0);                 // R6: early zero echo
    run_case(1000, 0, 64'hA5A5_5A5A_F00F_0FF0, 6, 1'b0); // R9 first stage
    run_case(0, 1000, 64'h1111_2222_3333_4444, 6, 1'b0); // R9 second stage
    run_case(2, PMAX-2, 64'hDEAD_BEEF_0000_FFFF, 5, 1'b0); // last allowed frame
    run_case(2, PMAX-1, 64'h8000_0000_0000_0001, 6, 1'b0); // one frame late
    run_case(1, 2, 64'h0F1E_2D3C_4B5A_6978, 5, 1'b1);    // R11
    report();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end
endmodule